// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt conditions of a FIFO-based UART and folds them into one read-only 8-bit identification value plus a single interrupt line to the CPU. It watches five sources: receive line errors, received data at or above the FIFO trigger level, a receive character timeout, the transmit holding register going empty, and a modem status change. Each source is gated by its own enable bit. The unit then reports the highest-priority source as a 3-bit code, with an active-low pending flag beside it.

The character-timeout counter lives inside the block. It counts oversampling baud ticks while the receive FIFO holds data and no FIFO read or write takes place. After four character times of silence it raises the timeout source, so that software can drain a partial block that never reaches the trigger level.

While software reads the identification value, the value is held frozen. Sources that change during the read are still recorded, and they show up once the read strobe drops. The identification output is registered, so it follows the live sources with one clock of latency.

Top module: `uart_int_id`

## Requirements
- R1: Bit 0 of `ident_o` is an active-low pending flag: 0 when any enabled source is pending, 1 otherwise. `irq_o` is its inverse. After reset `ident_o` is 8'h01 and `irq_o` is 0. When bit 0 is 1, bits 3:1 are 000.
- R2: Bits 3:1 carry the source code: 011 line error, 010 receive data, 110 receive timeout, 001 transmit empty, 000 modem change.
- R3: Priority from highest to lowest is: line error, then the shared receive level (receive data, then timeout), then transmit empty, then modem. Codes 100, 101 and 111 never appear.
- R4: Any set bit of `line_err_i` latches the line-error source. A `line_stat_rd_i` strobe clears it. A new error in the same cycle as the strobe wins.
- R5: The receive-data source is active while `rx_level_i` is at or above the trigger level. With FIFOs enabled, `trig_sel_i` 00/01/10/11 selects 1, depth/4, depth/2 and depth-2 (1, 4, 8, 14 for depth 16). With FIFOs disabled the trigger is 1. The source drops as soon as the level falls below the trigger.
- R6: The timeout source sets after 4 × `char_bits_i` × 16 baud ticks with `rx_level_i` nonzero and no `rx_rd_i`/`rx_wr_i`. This lies inside 3.5 to 4.5 character times. Any FIFO read or write, or an empty FIFO, clears it. It is reported only when the receive-data source is not active.
- R7: A rising edge of `tx_hold_empty_i` latches the transmit-empty source. It is cleared by `tx_hold_wr_i`, or by an identification read whose displayed value is code 001 with the pending flag low.
- R8: A `modem_chg_i` pulse latches the modem source. `modem_stat_rd_i` clears it.
- R9: `src_en_i` gates each source before prioritisation. Bit 0 gates receive data and timeout, bit 1 transmit empty, bit 2 line error and bit 3 modem. A disabled source that is latched stays latched and appears once it is enabled.
- R10: Bits 7:6 of `ident_o` both equal `fifo_en_i` as sampled with the rest of the value. Bits 5:4 are 0.
- R11: While `id_rd_i` is high, `ident_o` does not change. Otherwise it takes the live prioritised value at each clock edge. Sources that arrive during a read appear after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_err_i | input | 4 | Receive error flags (overrun, parity, framing, break), any order |
| rx_level_i | input | LVL_W | Current receive FIFO fill level |
| trig_sel_i | input | 2 | Receive trigger level select |
| rx_rd_i | input | 1 | Receive FIFO read strobe |
| rx_wr_i | input | 1 | Receive FIFO write strobe |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| char_bits_i | input | CB_W | Bits per character frame (5 or more) |
| tx_hold_empty_i | input | 1 | Transmit holding register empty level |
| tx_hold_wr_i | input | 1 | Transmit holding register write strobe |
| modem_chg_i | input | 1 | Modem status change pulse |
| src_en_i | input | 4 | Per-source enables |
| fifo_en_i | input | 1 | FIFO enable |
| id_rd_i | input | 1 | Identification read strobe |
| line_stat_rd_i | input | 1 | Line status read strobe |
| modem_stat_rd_i | input | 1 | Modem status read strobe |
| ident_o | output | 8 | Identification value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle: that no reserved code or nonzero reserved bit is ever shown, that the value holds steady through a read, and that a line-status or FIFO-activity strobe removes its source from the display two cycles later. They also check that the receive level beats transmit and modem whenever it is above the trigger. Only the bench scenarios can show the timeout arriving inside its window, the transmit source clearing through the read that reported it, events captured during a freeze, and the full ordering across mixed random traffic.

// File: rtl/uart_int_id_pkg.sv
package uart_int_id_pkg;

    typedef enum logic [2:0] {
        SRC_MODEM   = 3'b000,
        SRC_TXEMPTY = 3'b001,
        SRC_RXDATA  = 3'b010,
        SRC_LINE    = 3'b011,
        SRC_TIMEOUT = 3'b110
    } irq_src_e;

    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } irq_req_t;

    typedef struct packed {
        logic [1:0] fifo_mirror;
        logic [1:0] rsvd;
        irq_src_e   src;
        logic       no_pend;
    } ident_t;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    localparam ident_t IDENT_RESET = '{fifo_mirror: 2'b00, rsvd: 2'b00,
                                       src: SRC_MODEM, no_pend: 1'b1};

    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_int_id_timeout.sv
module uart_int_id_timeout #(
    parameter int LVL_W    = 5,
    parameter int CB_W     = 4,
    parameter int OVS      = 16,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick_i,
    input  logic [CB_W-1:0]  char_bits_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             rx_rd_i,
    input  logic             rx_wr_i,
    output logic             timeout_o
);
    localparam int TICKS_PER_BIT_WIN = OVS * TO_CHARS;
    localparam int CNT_W = CB_W + $clog2(TICKS_PER_BIT_WIN) + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             flag_q;
    logic             restart;

    assign limit   = CNT_W'(char_bits_i) * CNT_W'(TICKS_PER_BIT_WIN);
    assign restart = rx_rd_i || rx_wr_i || (rx_level_i == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (baud_tick_i && !flag_q) begin
            if (cnt_q == limit - CNT_W'(1)) begin
                cnt_q  <= '0;
                flag_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign timeout_o = flag_q;
endmodule

// File: rtl/uart_int_id_flags.sv
module uart_int_id_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] line_err_i,
    input  logic       line_stat_rd_i,
    input  logic       tx_hold_empty_i,
    input  logic       tx_hold_wr_i,
    input  logic       tx_ack_i,
    input  logic       modem_chg_i,
    input  logic       modem_stat_rd_i,
    output logic       line_o,
    output logic       txempty_o,
    output logic       modem_o
);
    logic line_q, tx_q, modem_q, tx_lvl_q;
    logic tx_rise;

    assign tx_rise = tx_hold_empty_i && !tx_lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= 1'b0;
            tx_q     <= 1'b0;
            modem_q  <= 1'b0;
            tx_lvl_q <= 1'b0;
        end else begin
            tx_lvl_q <= tx_hold_empty_i;
            if (|line_err_i)          line_q <= 1'b1;
            else if (line_stat_rd_i)  line_q <= 1'b0;
            if (tx_rise)                        tx_q <= 1'b1;
            else if (tx_hold_wr_i || tx_ack_i)  tx_q <= 1'b0;
            if (modem_chg_i)          modem_q <= 1'b1;
            else if (modem_stat_rd_i) modem_q <= 1'b0;
        end
    end

    assign line_o    = line_q;
    assign txempty_o = tx_q;
    assign modem_o   = modem_q;
endmodule

// File: rtl/uart_int_id_prio.sv
module uart_int_id_prio
    import uart_int_id_pkg::*;
(
    input  irq_req_t req_i,
    input  logic     fifo_en_i,
    output ident_t   ident_o
);
    always_comb begin
        ident_o             = IDENT_RESET;
        ident_o.fifo_mirror = {2{fifo_en_i}};
        if (req_i.line) begin
            ident_o.src     = SRC_LINE;
            ident_o.no_pend = 1'b0;
        end else if (req_i.rxdata) begin
            ident_o.src     = SRC_RXDATA;
            ident_o.no_pend = 1'b0;
        end else if (req_i.timeout) begin
            ident_o.src     = SRC_TIMEOUT;
            ident_o.no_pend = 1'b0;
        end else if (req_i.txempty) begin
            ident_o.src     = SRC_TXEMPTY;
            ident_o.no_pend = 1'b0;
        end else if (req_i.modem) begin
            ident_o.src     = SRC_MODEM;
            ident_o.no_pend = 1'b0;
        end
    end
endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
    import uart_int_id_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    parameter int TO_CHARS   = 4,
    parameter int CB_W       = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       line_err_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             rx_rd_i,
    input  logic             rx_wr_i,
    input  logic             baud_tick_i,
    input  logic [CB_W-1:0]  char_bits_i,
    input  logic             tx_hold_empty_i,
    input  logic             tx_hold_wr_i,
    input  logic             modem_chg_i,
    input  logic [3:0]       src_en_i,
    input  logic             fifo_en_i,
    input  logic             id_rd_i,
    input  logic             line_stat_rd_i,
    input  logic             modem_stat_rd_i,
    output logic [7:0]       ident_o,
    output logic             irq_o
);
    ident_t           view_q;
    ident_t           live;
    irq_req_t         req;
    logic [LVL_W-1:0] trig_lvl;
    logic             line_f, tx_f, modem_f, timeout_f;
    logic             rx_above;
    logic             tx_ack;

    assign tx_ack = id_rd_i && !view_q.no_pend && (view_q.src == SRC_TXEMPTY);

    uart_int_id_timeout #(
        .LVL_W(LVL_W), .CB_W(CB_W), .OVS(OVS), .TO_CHARS(TO_CHARS)
    ) u_timeout (
        .clk(clk), .rst(rst), .baud_tick_i(baud_tick_i),
        .char_bits_i(char_bits_i), .rx_level_i(rx_level_i),
        .rx_rd_i(rx_rd_i), .rx_wr_i(rx_wr_i), .timeout_o(timeout_f)
    );

    uart_int_id_flags u_flags (
        .clk(clk), .rst(rst),
        .line_err_i(line_err_i), .line_stat_rd_i(line_stat_rd_i),
        .tx_hold_empty_i(tx_hold_empty_i), .tx_hold_wr_i(tx_hold_wr_i),
        .tx_ack_i(tx_ack), .modem_chg_i(modem_chg_i),
        .modem_stat_rd_i(modem_stat_rd_i),
        .line_o(line_f), .txempty_o(tx_f), .modem_o(modem_f)
    );

    assign trig_lvl = fifo_en_i ? LVL_W'(trig_level(trig_sel_i, FIFO_DEPTH))
                                : LVL_W'(1);
    assign rx_above = rx_level_i >= trig_lvl;

    always_comb begin
        req.line    = line_f  && src_en_i[EN_LINE];
        req.rxdata  = rx_above && src_en_i[EN_RX];
        req.timeout = timeout_f && src_en_i[EN_RX] && !rx_above;
        req.txempty = tx_f    && src_en_i[EN_TX];
        req.modem   = modem_f && src_en_i[EN_MODEM];
    end

    uart_int_id_prio u_prio (
        .req_i(req), .fifo_en_i(fifo_en_i), .ident_o(live)
    );

    always_ff @(posedge clk) begin
        if (rst)           view_q <= IDENT_RESET;
        else if (!id_rd_i) view_q <= live;
    end

    assign ident_o = view_q;
    assign irq_o   = !view_q.no_pend;
endmodule

// File: rtl/uart_int_id_chk.sv
module uart_int_id_chk
    import uart_int_id_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       line_err_i,
    input logic [LVL_W-1:0] rx_level_i,
    input logic [1:0]       trig_sel_i,
    input logic             rx_rd_i,
    input logic             rx_wr_i,
    input logic [3:0]       src_en_i,
    input logic             fifo_en_i,
    input logic             id_rd_i,
    input logic             line_stat_rd_i,
    input logic [7:0]       ident_o,
    input logic             irq_o
);
    logic [LVL_W-1:0] chk_trig;
    assign chk_trig = fifo_en_i ? LVL_W'(trig_level(trig_sel_i, FIFO_DEPTH))
                                : LVL_W'(1);

    assert_no_reserved_code_R3: assert property (@(posedge clk) disable iff (rst)
        ident_o[3:1] != 3'b100 && ident_o[3:1] != 3'b101 && ident_o[3:1] != 3'b111);

    assert_idle_code_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (ident_o[0] |-> ident_o[3:1] == 3'b000) && (irq_o != ident_o[0]));

    assert_fixed_bits_R10: assert property (@(posedge clk) disable iff (rst)
        ident_o[7] == ident_o[6] && ident_o[5:4] == 2'b00);

    assert_frozen_read_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(id_rd_i)) |-> $stable(ident_o));

    assert_line_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(line_stat_rd_i, 2)
         && $past(line_err_i, 2) == 4'b0000 && !$past(id_rd_i))
        |-> ident_o[3:1] != 3'b011);

    assert_timeout_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ($past(rx_rd_i, 2) || $past(rx_wr_i, 2))
         && !$past(id_rd_i))
        |-> ident_o[3:1] != 3'b110);

    assert_rx_level_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(id_rd_i) && $past(src_en_i[EN_RX])
         && !$past(src_en_i[EN_LINE]) && $past(rx_level_i >= chk_trig))
        |-> (ident_o[3:1] == 3'b010 && !ident_o[0]));
endmodule

bind uart_int_id uart_int_id_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst(rst), .line_err_i(line_err_i), .rx_level_i(rx_level_i),
    .trig_sel_i(trig_sel_i), .rx_rd_i(rx_rd_i), .rx_wr_i(rx_wr_i),
    .src_en_i(src_en_i), .fifo_en_i(fifo_en_i), .id_rd_i(id_rd_i),
    .line_stat_rd_i(line_stat_rd_i), .ident_o(ident_o), .irq_o(irq_o)
);

// File: tb/test_uart_int_id.sv
module test_uart_int_id;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int LVL_W = 5;
    localparam int CB_W  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]       line_err = '0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [1:0]       trig_sel = '0;
    logic             rx_rd = 1'b0, rx_wr = 1'b0, baud_tick = 1'b0;
    logic [CB_W-1:0]  char_bits = 4'd10;
    logic             thr_empty = 1'b0, thr_wr = 1'b0, mchg = 1'b0;
    logic [3:0]       en = '0;
    logic             fifo_en = 1'b0, id_rd = 1'b0, ls_rd = 1'b0, ms_rd = 1'b0;
    logic [7:0]       ident;
    logic             irq;

    int checks = 0;
    int errors = 0;
    bit rand_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_int_id i_uart_int_id (
        .clk(clk), .rst(rst), .line_err_i(line_err), .rx_level_i(rx_level),
        .trig_sel_i(trig_sel), .rx_rd_i(rx_rd), .rx_wr_i(rx_wr),
        .baud_tick_i(baud_tick), .char_bits_i(char_bits),
        .tx_hold_empty_i(thr_empty), .tx_hold_wr_i(thr_wr),
        .modem_chg_i(mchg), .src_en_i(en), .fifo_en_i(fifo_en),
        .id_rd_i(id_rd), .line_stat_rd_i(ls_rd), .modem_stat_rd_i(ms_rd),
        .ident_o(ident), .irq_o(irq)
    );

    // Reference model built from the requirements
    bit m_line, m_tx, m_mod, m_cti, m_thr_d;
    int m_cnt;
    logic [7:0] m_view = 8'h01;

    function automatic int trig_of(input logic [1:0] s, input logic fe);
        if (!fe) return 1;
        case (s)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    function automatic logic [7:0] exp_ident();
        bit rda;
        logic [2:0] code;
        bit pend;
        rda  = en[0] && (int'(rx_level) >= trig_of(trig_sel, fifo_en));
        pend = 1'b1;
        if (en[2] && m_line)             code = 3'b011;
        else if (rda)                    code = 3'b010;
        else if (en[0] && m_cti)         code = 3'b110;
        else if (en[1] && m_tx)          code = 3'b001;
        else if (en[3] && m_mod)         code = 3'b000;
        else begin code = 3'b000; pend = 1'b0; end
        return {fifo_en, fifo_en, 2'b00, code, !pend};
    endfunction

    always @(posedge clk) begin
        logic [7:0] live;
        bit ack;
        if (rst) begin
            m_line = 0; m_tx = 0; m_mod = 0; m_cti = 0; m_thr_d = 0;
            m_cnt = 0; m_view = 8'h01;
        end else begin
            live = exp_ident();
            ack  = id_rd && m_view[3:1] == 3'b001 && !m_view[0];
            if (!id_rd) m_view = live;
            if (|line_err) m_line = 1; else if (ls_rd) m_line = 0;
            if (thr_empty && !m_thr_d) m_tx = 1; else if (thr_wr || ack) m_tx = 0;
            m_thr_d = thr_empty;
            if (mchg) m_mod = 1; else if (ms_rd) m_mod = 0;
            if (rx_rd || rx_wr || rx_level == 0) begin
                m_cnt = 0; m_cti = 0;
            end else if (baud_tick && !m_cti) begin
                if (m_cnt == int'(char_bits) * 64 - 1) begin m_cti = 1; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp || irq !== !exp[0]) begin
            errors++;
            $display("FAIL %s ident=%02h irq=%0b expected ident=%02h irq=%0b",
                     req, act, irq, exp, !exp[0]);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string tag_of(input logic [7:0] v);
        if (v[0]) return "R1";
        case (v[3:1])
            3'b011: return "R4";
            3'b010: return "R5";
            3'b110: return "R6";
            3'b001: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        cycles(3);
        rst = 1'b0;
        cycles(1);
        check(ident, 8'h01, "R1 reset");

        fifo_en = 1; en = 4'hF; cycles(2);
        check(ident, 8'hC1, "R10 fifo mirror");

        // line error beats modem; clears on status read (R3, R4, R8, R2)
        mchg = 1; cycles(1); mchg = 0;
        line_err = 4'b0100; cycles(1); line_err = 0; cycles(1);
        check(ident, 8'hC6, "R3 line over modem");
        ls_rd = 1; cycles(1); ls_rd = 0; cycles(1);
        check(ident, 8'hC0, "R4 line cleared, R2 modem code");
        ms_rd = 1; cycles(1); ms_rd = 0; cycles(1);
        check(ident, 8'hC1, "R8 modem cleared");

        // receive trigger (R5)
        trig_sel = 2'd1; rx_level = 3; cycles(2);
        check(ident, 8'hC1, "R5 below trigger");
        rx_level = 4; cycles(2);
        check(ident, 8'hC4, "R5 at trigger");
        line_err = 4'b0001; cycles(1); line_err = 0; cycles(1);
        check(ident, 8'hC6, "R3 line over receive data");
        ls_rd = 1; cycles(1); ls_rd = 0;
        en = 4'b1110; cycles(2);
        check(ident, 8'hC1, "R9 receive disabled");
        en = 4'hF; rx_level = 3; cycles(2);
        check(ident, 8'hC1, "R5 drop below trigger");

        // enable gating of a held source (R9)
        en = 4'b1011; line_err = 4'b1000; cycles(1); line_err = 0; cycles(1);
        check(ident, 8'hC1, "R9 line masked");
        en = 4'hF; cycles(2);
        check(ident, 8'hC6, "R9 held line shows when enabled");
        ls_rd = 1; cycles(1); ls_rd = 0; cycles(1);

        // character timeout (R6): 10 bits -> 640 ticks
        baud_tick = 1; rx_level = 2;
        rx_wr = 1; cycles(1); rx_wr = 0;
        cycles(540);
        check(ident, 8'hC1, "R6 quiet before 3.5 chars");
        cycles(200);
        check(ident, 8'hCC, "R6 timeout by 4.5 chars");
        rx_level = 4; cycles(2);
        check(ident, 8'hC4, "R6 hidden by receive data");
        rx_level = 2; cycles(2);
        check(ident, 8'hCC, "R6 returns below trigger");
        rx_rd = 1; cycles(1); rx_rd = 0; cycles(1);
        check(ident, 8'hC1, "R6 cleared by read");
        rx_level = 0; baud_tick = 0; cycles(1);

        // transmit empty (R7)
        thr_empty = 1; cycles(2);
        check(ident, 8'hC2, "R7 tx empty raised");
        id_rd = 1; cycles(1); id_rd = 0; cycles(1);
        check(ident, 8'hC1, "R7 cleared by ident read");
        thr_empty = 0; cycles(1); thr_empty = 1; cycles(2);
        check(ident, 8'hC2, "R7 raised again");
        mchg = 1; cycles(1); mchg = 0; cycles(1);
        check(ident, 8'hC2, "R3 tx over modem");
        thr_wr = 1; cycles(1); thr_wr = 0; cycles(1);
        check(ident, 8'hC0, "R7 cleared by holding write");
        ms_rd = 1; cycles(1); ms_rd = 0; cycles(1);

        // freeze during read (R11)
        id_rd = 1; cycles(1);
        line_err = 4'b0010; cycles(1); line_err = 0; cycles(2);
        check(ident, 8'hC1, "R11 frozen during read");
        id_rd = 0; cycles(1);
        check(ident, 8'hC6, "R11 event shown after read");
        ls_rd = 1; cycles(1); ls_rd = 0; cycles(1);

        // FIFO disabled trigger (R5, R10)
        fifo_en = 0; trig_sel = 2'd3; rx_level = 1; cycles(2);
        check(ident, 8'h04, "R5 trigger one when fifo off");
        rx_level = 0; cycles(2);
        check(ident, 8'h01, "R10 mirror cleared");

        // random traffic against the model
        rand_on = 1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            check(ident, m_view, tag_of(m_view));
            if (i % 300 == 0) begin
                en = 4'($urandom);
                fifo_en = 1'($urandom);
                trig_sel = 2'($urandom);
                char_bits = 4'(5 + $urandom_range(0, 3));
            end
            line_err  = ($urandom_range(0, 49) == 0) ? 4'($urandom) : 4'h0;
            rx_level  = ($urandom_range(0, 99) == 0) ? 5'($urandom_range(0, DEPTH)) : rx_level;
            rx_rd     = ($urandom_range(0, 599) == 0);
            rx_wr     = ($urandom_range(0, 599) == 0);
            baud_tick = 1'($urandom);
            thr_empty = ($urandom_range(0, 19) == 0) ? !thr_empty : thr_empty;
            thr_wr    = ($urandom_range(0, 59) == 0);
            mchg      = ($urandom_range(0, 49) == 0);
            id_rd     = ($urandom_range(0, 7) == 0);
            ls_rd     = ($urandom_range(0, 29) == 0);
            ms_rd     = ($urandom_range(0, 29) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule